// File: doc/BRIEF.md
# Tagged DMA Command Queue

This block sits between a local processor and a data-transfer engine. The processor writes DMA commands through a write port: a local-store address, an external address, a byte count, a direction and a tag. Each command is first checked for size and alignment. A legal command joins a first-in, first-out queue. An illegal one is discarded and raises a sticky error flag. The engine takes the oldest command through a valid/ready pair. When that transfer has finished, the engine reports the command's tag on a completion strobe. Because the queue goes on accepting commands while earlier ones are still in flight, their latencies overlap.

Each tag has a counter of the commands that carry it and have not yet completed. A tag is pending while its counter is not zero. The processor asks about a group of tags with a 32-bit mask. In "any" mode the group is satisfied when at least one tag in the mask is idle. In "all" mode it is satisfied when every tag in the mask is idle. A query either returns at once (poll) or waits until the group is satisfied (block). A small state machine with the states Q_IDLE, Q_WAIT and Q_REPLY runs each query. It has four transitions:
- *poll-or-ready*: Q_IDLE to Q_REPLY, for a poll or for a block that is already satisfied.
- *park*: Q_IDLE to Q_WAIT, for a block that is not yet satisfied.
- *release*: Q_WAIT to Q_REPLY, once the group is satisfied.
- *retire*: Q_REPLY to Q_IDLE.

Top module: `dma_cmd_queue`

## Requirements
- R1: The queue holds up to 16 commands and presents them on the engine port in the order they were accepted. `eng_valid` is high whenever at least one command is held.
- R2: `cmd_stall` is high exactly when 16 commands are held. A command offered while `cmd_stall` is high is not taken and has no effect on the queue or the tags.
- R3: While `eng_valid` is high and `eng_ready` is low, the presented command does not change. A command leaves the queue only on a cycle with both signals high.
- R4: A size of 1, 2, 4 or 8 bytes is legal only when both addresses have identical bits [3:0] and the local address is a multiple of the size.
- R5: A size that is a non-zero multiple of 16 and at most 16384 is legal only when bits [3:0] of both addresses are zero. Every other size, including 0, is illegal.
- R6: An illegal command that is not stalled is dropped, and `cmd_err` goes high on the next cycle. It stays high until reset.
- R7: Accepting a command sets `tag_pending` for its tag on the next cycle. Each completion for that tag removes one outstanding command. The bit clears when the last one completes. A completion for a tag with nothing outstanding is ignored.
- R8: A poll query (`qry_wait`=0) is accepted in Q_IDLE. It answers on the next cycle with a one-cycle `qry_done` pulse. `qry_status` then equals mask AND NOT pending, and `qry_met` gives the satisfied result.
- R9: `qry_all`=0 selects "any" mode: satisfied when some masked tag is not pending. `qry_all`=1 selects "all" mode: satisfied when no masked tag is pending. A zero mask is always satisfied.
- R10: A blocking query (`qry_wait`=1) that is not yet satisfied keeps `qry_busy` high in Q_WAIT. It answers one cycle after the pending bits satisfy it. Queries offered while `qry_busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_ls_addr | input | LS_AW | Local-store byte address |
| cmd_ext_addr | input | EA_W | External byte address |
| cmd_size | input | SIZE_W | Transfer size in bytes |
| cmd_dir | input | 1 | 0 = fetch into local store, 1 = store out |
| cmd_tag | input | TAG_W | Tag group of the command |
| cmd_stall | output | 1 | Queue full; write not taken |
| cmd_err | output | 1 | Sticky illegal-command flag |
| eng_valid | output | 1 | A command is presented to the engine |
| eng_ready | input | 1 | Engine takes the presented command |
| eng_ls_addr | output | LS_AW | Head local-store address |
| eng_ext_addr | output | EA_W | Head external address |
| eng_size | output | SIZE_W | Head size |
| eng_dir | output | 1 | Head direction |
| eng_tag | output | TAG_W | Head tag |
| done_valid | input | 1 | Completion strobe from the engine |
| done_tag | input | TAG_W | Tag of the completed command |
| tag_pending | output | NTAGS | One bit per tag with commands outstanding |
| qry_valid | input | 1 | Tag-status query strobe |
| qry_mask | input | NTAGS | Tags the query covers |
| qry_all | input | 1 | 0 = any mode, 1 = all mode |
| qry_wait | input | 1 | 0 = poll, 1 = block until satisfied |
| qry_busy | output | 1 | A query is being served |
| qry_done | output | 1 | One-cycle answer strobe |
| qry_met | output | 1 | Query condition satisfied at answer |
| qry_status | output | NTAGS | Masked tags that were idle at answer |

## Verification
The hardest situation to reach from the ports is a blocking query that has parked in Q_WAIT and must leave on exactly the right cycle. To get there, a tag is first made pending by enqueuing a command for it. An "all"-mode blocking query then waits on that tag, and a second query is offered while the first is busy to show that it is ignored. The completion is sent only after several idle cycles, and the answer is sampled one cycle after the pending bit drops. The full-queue case is reached by filling all 16 slots while the engine holds off. A 17th command is then offered under stall, and the bench confirms that its distinct tag never becomes pending and never reaches the engine.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;

    typedef enum logic [1:0] {
        Q_IDLE  = 2'd0,
        Q_WAIT  = 2'd1,
        Q_REPLY = 2'd2
    } qry_state_t;

    typedef enum logic {
        DIR_FETCH = 1'b0,
        DIR_STORE = 1'b1
    } dma_dir_t;

endpackage

// File: rtl/dma_cmd_legal.sv
module dma_cmd_legal #(
    parameter int LS_AW    = 18,
    parameter int EA_W     = 32,
    parameter int SIZE_W   = 15,
    parameter int MAX_XFER = 16384
) (
    input  logic [LS_AW-1:0]  ls_addr,
    input  logic [EA_W-1:0]   ext_addr,
    input  logic [SIZE_W-1:0] size,
    output logic              legal
);
    logic       small_sz;
    logic       big_sz;
    logic [3:0] size_low_mask;
    logic       small_ok;
    logic       big_ok;

    always_comb begin
        small_sz = (size == SIZE_W'(1)) || (size == SIZE_W'(2)) ||
                   (size == SIZE_W'(4)) || (size == SIZE_W'(8));
        big_sz   = (size[3:0] == 4'd0) && (size != '0) &&
                   (size <= SIZE_W'(MAX_XFER));
        size_low_mask = size[3:0] - 4'd1;
        small_ok = (ls_addr[3:0] == ext_addr[3:0]) &&
                   ((ls_addr[3:0] & size_low_mask) == 4'd0);
        big_ok   = (ls_addr[3:0] == 4'd0) && (ext_addr[3:0] == 4'd0);
        legal    = (small_sz && small_ok) || (big_sz && big_ok);
    end
endmodule

// File: rtl/dma_cmd_fifo.sv
module dma_cmd_fifo #(
    parameter int W     = 72,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [PW:0]   count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign full  = (count == (PW+1)'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/dma_tag_tracker.sv
module dma_tag_tracker #(
    parameter int NTAGS = 32,
    parameter int CNT_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inc_valid,
    input  logic [$clog2(NTAGS)-1:0] inc_tag,
    input  logic                     dec_valid,
    input  logic [$clog2(NTAGS)-1:0] dec_tag,
    output logic [NTAGS-1:0]         pending
);
    localparam int TAG_W = $clog2(NTAGS);

    for (genvar t = 0; t < NTAGS; t++) begin : g_tag
        logic [CNT_W-1:0] cnt;
        logic             inc, dec;

        assign inc = inc_valid && (inc_tag == TAG_W'(t));
        assign dec = dec_valid && (dec_tag == TAG_W'(t)) && (cnt != '0);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (inc && !dec) begin
                cnt <= cnt + 1'b1;
            end else if (dec && !inc) begin
                cnt <= cnt - 1'b1;
            end
        end

        assign pending[t] = (cnt != '0);
    end
endmodule

// File: rtl/dma_tag_query.sv
module dma_tag_query
    import dma_cmd_pkg::*;
#(
    parameter int NTAGS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qry_valid,
    input  logic [NTAGS-1:0] qry_mask,
    input  logic             qry_all,
    input  logic             qry_wait,
    input  logic [NTAGS-1:0] pending,
    output logic             qry_busy,
    output logic             qry_done,
    output logic             qry_met,
    output logic [NTAGS-1:0] qry_status
);
    qry_state_t       state, state_nx;
    logic [NTAGS-1:0] mask_q;
    logic             all_q;
    logic [NTAGS-1:0] cur_mask;
    logic             cur_all;
    logic             sat;

    function automatic logic satisfied(input logic [NTAGS-1:0] m,
                                       input logic             all_mode,
                                       input logic [NTAGS-1:0] pend);
        if (m == '0)   return 1'b1;
        if (all_mode)  return (m & pend) == '0;
        return (m & ~pend) != '0;
    endfunction

    always_comb begin
        cur_mask = (state == Q_IDLE) ? qry_mask : mask_q;
        cur_all  = (state == Q_IDLE) ? qry_all  : all_q;
        sat      = satisfied(cur_mask, cur_all, pending);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            Q_IDLE: begin
                if (qry_valid) begin
                    state_nx = (!qry_wait || sat) ? Q_REPLY : Q_WAIT;
                end
            end
            Q_WAIT:  if (sat) state_nx = Q_REPLY;
            Q_REPLY: state_nx = Q_IDLE;
            default: state_nx = Q_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= Q_IDLE;
            mask_q     <= '0;
            all_q      <= 1'b0;
            qry_met    <= 1'b0;
            qry_status <= '0;
        end else begin
            state <= state_nx;
            if (state == Q_IDLE && qry_valid) begin
                mask_q <= qry_mask;
                all_q  <= qry_all;
            end
            if (state_nx == Q_REPLY) begin
                qry_met    <= sat;
                qry_status <= cur_mask & ~pending;
            end
        end
    end

    always_comb begin
        qry_busy = (state != Q_IDLE);
        qry_done = (state == Q_REPLY);
    end
endmodule

// File: rtl/dma_cmd_queue.sv
module dma_cmd_queue
    import dma_cmd_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int NTAGS    = 32,
    parameter int LS_AW    = 18,
    parameter int EA_W     = 32,
    parameter int MAX_XFER = 16384,
    parameter int CNT_W    = 6,
    parameter int TAG_W    = $clog2(NTAGS),
    parameter int SIZE_W   = $clog2(MAX_XFER) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [LS_AW-1:0]  cmd_ls_addr,
    input  logic [EA_W-1:0]   cmd_ext_addr,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic              cmd_dir,
    input  logic [TAG_W-1:0]  cmd_tag,
    output logic              cmd_stall,
    output logic              cmd_err,
    output logic              eng_valid,
    input  logic              eng_ready,
    output logic [LS_AW-1:0]  eng_ls_addr,
    output logic [EA_W-1:0]   eng_ext_addr,
    output logic [SIZE_W-1:0] eng_size,
    output logic              eng_dir,
    output logic [TAG_W-1:0]  eng_tag,
    input  logic              done_valid,
    input  logic [TAG_W-1:0]  done_tag,
    output logic [NTAGS-1:0]  tag_pending,
    input  logic              qry_valid,
    input  logic [NTAGS-1:0]  qry_mask,
    input  logic              qry_all,
    input  logic              qry_wait,
    output logic              qry_busy,
    output logic              qry_done,
    output logic              qry_met,
    output logic [NTAGS-1:0]  qry_status
);
    localparam int ENTRY_W = LS_AW + EA_W + SIZE_W + 1 + TAG_W;

    logic               cmd_legal;
    logic               q_full, q_empty;
    logic               push, pop;
    logic [ENTRY_W-1:0] entry_in, entry_head;
    dma_dir_t           head_dir;

    dma_cmd_legal #(
        .LS_AW(LS_AW), .EA_W(EA_W), .SIZE_W(SIZE_W), .MAX_XFER(MAX_XFER)
    ) u_legal (
        .ls_addr (cmd_ls_addr),
        .ext_addr(cmd_ext_addr),
        .size    (cmd_size),
        .legal   (cmd_legal)
    );

    assign cmd_stall = q_full;
    assign push      = cmd_valid && !q_full && cmd_legal;
    assign pop       = eng_valid && eng_ready;
    assign entry_in  = {cmd_ls_addr, cmd_ext_addr, cmd_size, cmd_dir, cmd_tag};

    dma_cmd_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_data(entry_in),
        .pop      (pop),
        .head     (entry_head),
        .full     (q_full),
        .empty    (q_empty)
    );

    assign eng_valid = !q_empty;
    always_comb begin
        {eng_ls_addr, eng_ext_addr, eng_size, head_dir, eng_tag} = entry_head;
        eng_dir = (head_dir == DIR_STORE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_err <= 1'b0;
        end else if (cmd_valid && !q_full && !cmd_legal) begin
            cmd_err <= 1'b1;
        end
    end

    dma_tag_tracker #(.NTAGS(NTAGS), .CNT_W(CNT_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_valid(push),
        .inc_tag  (cmd_tag),
        .dec_valid(done_valid),
        .dec_tag  (done_tag),
        .pending  (tag_pending)
    );

    dma_tag_query #(.NTAGS(NTAGS)) u_query (
        .clk       (clk),
        .rst_n     (rst_n),
        .qry_valid (qry_valid),
        .qry_mask  (qry_mask),
        .qry_all   (qry_all),
        .qry_wait  (qry_wait),
        .pending   (tag_pending),
        .qry_busy  (qry_busy),
        .qry_done  (qry_done),
        .qry_met   (qry_met),
        .qry_status(qry_status)
    );
endmodule

// File: rtl/dma_cmd_queue_sva.sv
module dma_cmd_queue_sva #(
    parameter int NTAGS    = 32,
    parameter int TAG_W    = 5,
    parameter int SIZE_W   = 15,
    parameter int MAX_XFER = 16384
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_stall,
    input logic              cmd_legal,
    input logic [TAG_W-1:0]  cmd_tag,
    input logic              cmd_err,
    input logic              eng_valid,
    input logic              eng_ready,
    input logic [TAG_W-1:0]  eng_tag,
    input logic [SIZE_W-1:0] eng_size,
    input logic              qry_done,
    input logic [NTAGS-1:0]  tag_pending
);
    // R3: presented command held while the engine is not ready
    a_r3_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_ready) |=> (eng_valid && $stable(eng_tag) && $stable(eng_size)));

    // R5: only sizes within the legal range ever reach the engine
    a_r5_size_bound: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |-> (eng_size != '0 && eng_size <= SIZE_W'(MAX_XFER)));

    // R6: an illegal, unstalled command raises the error flag
    a_r6_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_stall && !cmd_legal) |=> cmd_err);

    // R6: the error flag is sticky
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);

    // R7: an accepted command makes its tag pending
    a_r7_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_stall && cmd_legal) |=> tag_pending[$past(cmd_tag)]);

    // R8: the answer strobe lasts a single cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        qry_done |=> !qry_done);
endmodule

bind dma_cmd_queue dma_cmd_queue_sva #(
    .NTAGS(NTAGS), .TAG_W(TAG_W), .SIZE_W(SIZE_W), .MAX_XFER(MAX_XFER)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_stall  (cmd_stall),
    .cmd_legal  (cmd_legal),
    .cmd_tag    (cmd_tag),
    .cmd_err    (cmd_err),
    .eng_valid  (eng_valid),
    .eng_ready  (eng_ready),
    .eng_tag    (eng_tag),
    .eng_size   (eng_size),
    .qry_done   (qry_done),
    .tag_pending(tag_pending)
);

// File: tb/dma_cmd_queue_test.sv
module dma_cmd_queue_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [17:0] cmd_ls_addr = '0;
    logic [31:0] cmd_ext_addr = '0;
    logic [14:0] cmd_size = '0;
    logic        cmd_dir = 1'b0;
    logic [4:0]  cmd_tag = '0;
    logic        cmd_stall, cmd_err, eng_valid;
    logic        eng_ready = 1'b0;
    logic [17:0] eng_ls_addr;
    logic [31:0] eng_ext_addr;
    logic [14:0] eng_size;
    logic        eng_dir;
    logic [4:0]  eng_tag;
    logic        done_valid = 1'b0;
    logic [4:0]  done_tag = '0;
    logic [31:0] tag_pending;
    logic        qry_valid = 1'b0;
    logic [31:0] qry_mask = '0;
    logic        qry_all = 1'b0;
    logic        qry_wait = 1'b0;
    logic        qry_busy, qry_done, qry_met;
    logic [31:0] qry_status;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [4:0] got [32];
    int ngot;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_cmd_queue uut (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic push(input logic [17:0] ls, input logic [31:0] ea,
                        input logic [14:0] sz, input logic [4:0] tg);
        cmd_ls_addr = ls; cmd_ext_addr = ea; cmd_size = sz; cmd_tag = tg;
        cmd_dir = tg[0]; cmd_valid = 1'b1;
        step();
        cmd_valid = 1'b0;
    endtask

    task automatic complete(input logic [4:0] tg);
        done_valid = 1'b1; done_tag = tg;
        step();
        done_valid = 1'b0;
    endtask

    task automatic drain();
        ngot = 0;
        eng_ready = 1'b1;
        while (eng_valid && ngot < 32) begin
            got[ngot] = eng_tag;
            ngot++;
            step();
        end
        eng_ready = 1'b0;
    endtask

    task automatic t_reset();
        check(!cmd_stall && !cmd_err && !eng_valid, "R1 reset outputs", {cmd_stall, cmd_err, eng_valid}, 0);
        check(tag_pending == 0 && !qry_busy && !qry_done, "R7 reset pending", tag_pending, 0);
    endtask

    task automatic t_order_and_hold();
        push(18'h100, 32'h1000, 15'd32, 5'd1);
        push(18'h200, 32'h2000, 15'd16, 5'd2);
        push(18'h300, 32'h3000, 15'd48, 5'd3);
        check(eng_valid && eng_tag == 1 && eng_size == 32, "R1 head is oldest", eng_tag, 1);
        step(); step();
        check(eng_tag == 1 && eng_ls_addr == 18'h100, "R3 head held without ready", eng_tag, 1);
        check(tag_pending == 32'h0000_000E, "R7 pending after enqueue", tag_pending, 32'hE);
        drain();
        check(ngot == 3 && got[0] == 1 && got[1] == 2 && got[2] == 3, "R1 FIFO order", ngot, 3);
        complete(1); complete(2); complete(3);
        check(tag_pending == 0, "R7 all done", tag_pending, 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < 16; i++) push(18'h40 * i, 32'h8000 + 32'h40 * i, 15'd64, 5'(i));
        check(cmd_stall, "R2 stall when 16 held", cmd_stall, 1);
        push(18'h0, 32'h0, 15'd16, 5'd20);
        check(!tag_pending[20] && !cmd_err, "R2 stalled command has no effect", tag_pending[20], 0);
        drain();
        check(ngot == 16, "R2 only 16 entries leave", ngot, 16);
        for (int i = 0; i < 16; i++) check(got[i] == 5'(i), "R1 order over full queue", got[i], i);
        check(!cmd_stall && !eng_valid, "R2 stall releases", cmd_stall, 0);
        for (int i = 0; i < 16; i++) complete(5'(i));
        check(tag_pending == 0, "R7 cleared after full drain", tag_pending, 0);
    endtask

    task automatic t_legality();
        push(18'h13,  32'h7773, 15'd1,     5'd1);
        push(18'h108, 32'h2008, 15'd8,     5'd2);
        push(18'h200, 32'h3000, 15'd80,    5'd3);
        push(18'h0,   32'h10000, 15'd16384, 5'd4);
        check(!cmd_err && tag_pending == 32'h1E, "R4 R5 legal commands accepted", tag_pending, 32'h1E);
        push(18'h4, 32'h8, 15'd4, 5'd8);
        check(cmd_err && !tag_pending[8], "R4 nibble mismatch dropped", {cmd_err, tag_pending[8]}, 2);
        push(18'h3, 32'h3, 15'd2, 5'd9);
        check(!tag_pending[9], "R4 misaligned size 2 dropped", tag_pending[9], 0);
        push(18'h0, 32'h0, 15'd3, 5'd10);
        check(!tag_pending[10], "R5 size 3 dropped", tag_pending[10], 0);
        push(18'h0, 32'h0, 15'd0, 5'd12);
        check(!tag_pending[12], "R5 size 0 dropped", tag_pending[12], 0);
        push(18'h0, 32'h0, 15'd16400, 5'd13);
        check(!tag_pending[13], "R5 size over 16384 dropped", tag_pending[13], 0);
        push(18'h8, 32'h8, 15'd32, 5'd14);
        check(!tag_pending[14], "R5 unaligned multiple of 16 dropped", tag_pending[14], 0);
        drain();
        check(ngot == 4 && got[0] == 1 && got[3] == 4, "R6 illegal never reach engine", ngot, 4);
        for (int i = 1; i <= 4; i++) complete(5'(i));
        check(cmd_err, "R6 error flag sticky", cmd_err, 1);
    endtask

    task automatic t_tags();
        push(18'h0, 32'h0, 15'd16, 5'd5);
        push(18'h0, 32'h0, 15'd16, 5'd5);
        push(18'h0, 32'h0, 15'd16, 5'd6);
        complete(5);
        check(tag_pending[5], "R7 still pending after first of two", tag_pending[5], 1);
        complete(5);
        check(!tag_pending[5] && tag_pending[6], "R7 cleared after last", tag_pending, 32'h40);
        complete(9);
        check(tag_pending == 32'h40, "R7 completion for idle tag ignored", tag_pending, 32'h40);
        complete(6);
        check(tag_pending == 0, "R7 tag 6 cleared", tag_pending, 0);
        drain();
    endtask

    task automatic query(input logic [31:0] m, input logic all_mode, input logic blk);
        qry_mask = m; qry_all = all_mode; qry_wait = blk; qry_valid = 1'b1;
        step();
        qry_valid = 1'b0;
    endtask

    task automatic t_poll();
        push(18'h0, 32'h0, 15'd16, 5'd5);
        query(32'hA0, 1'b0, 1'b0);
        check(qry_done && qry_met && qry_status == 32'h80, "R8 R9 any-mode poll met", qry_status, 32'h80);
        step();
        check(!qry_done && !qry_busy, "R8 answer lasts one cycle", qry_done, 0);
        query(32'hA0, 1'b1, 1'b0);
        check(qry_done && !qry_met && qry_status == 32'h80, "R9 all-mode poll not met", qry_met, 0);
        step();
        query(32'h0, 1'b0, 1'b0);
        check(qry_done && qry_met, "R9 zero mask met", qry_met, 1);
        step();
    endtask

    task automatic t_block();
        push(18'h0, 32'h0, 15'd16, 5'd4);
        query(32'h10, 1'b1, 1'b1);
        check(qry_busy && !qry_done, "R10 parked while tag pending", qry_busy, 1);
        step(); step(); step();
        query(32'h0, 1'b0, 1'b0);
        check(qry_busy && !qry_done, "R10 query while busy ignored", qry_done, 0);
        complete(4);
        check(qry_busy && !qry_done, "R10 not yet answered on completion edge", qry_done, 0);
        step();
        check(qry_done && qry_met && qry_status == 32'h10, "R10 released after tag idle", qry_status, 32'h10);
        step();
        check(!qry_done && !qry_busy, "R10 back to idle", qry_busy, 0);
        complete(5);
        drain();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_order_and_hold();
        t_full();
        t_legality();
        t_tags();
        t_poll();
        t_block();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule